// File: doc/BRIEF.md
# Low-Pin-Count Firmware Memory Target

This block is the bus-facing front end of a firmware memory that sits on a 4-bit multiplexed low-pin-count bus. It watches a shared nibble bus and a frame strobe. It decodes memory read and memory write frames and keeps only those whose address carries its own device number. For those frames it hands one byte to, or takes one byte from, an internal byte port. Address bit 22 steers that port to the storage array or to the register space.

On the bus the block acts as a target. It lets the host finish the first turnaround cycle, then takes the bus. It drives a fixed number of short-wait sync nibbles, a ready sync nibble and the data nibbles. It closes every transfer with one all-ones nibble and then releases the bus. If the host pulls the frame strobe low in the middle of a transfer, the block drops the bus at once and looks for a new start.

The control is a single state machine with these states:
- `ST_IDLE`: no frame in progress.
- `ST_CYC`: cycle-type nibble.
- `ST_ADDR`: eight address nibbles.
- `ST_R_TAR0` and `ST_R_TAR1`: the read turnaround.
- `ST_R_SW0` and `ST_R_SW1`: the two wait syncs.
- `ST_R_RDY`: the ready sync.
- `ST_R_D0` and `ST_R_D1`: the read data nibbles.
- `ST_W_D0` and `ST_W_D1`: the write data nibbles.
- `ST_W_TAR0` and `ST_W_TAR1`: the write turnaround.
- `ST_W_SYNC`: the write sync.
- `ST_END_TAR`: the closing all-ones nibble.

The transitions are as follows:
- Start: from any state when the strobe is low and the bus is 0000b, go to `ST_CYC`.
- Abort: from any state when the strobe is low with any other nibble, go to `ST_IDLE`.
- Type check: from `ST_CYC`, a valid type goes to `ST_ADDR` and an invalid one goes to `ST_IDLE`.
- Address decode: after the eighth address nibble, a miss goes to `ST_IDLE`. A hit goes to `ST_R_TAR0` for a read or to `ST_W_D0` for a write.
- All other states step in a fixed order. The read path ends with `ST_R_D1`, the write path ends with `ST_W_SYNC`, and both then pass through `ST_END_TAR` to `ST_IDLE`.

Top module: `lpc_fw_target`

## Requirements
- R1: A frame begins on a rising clock edge that sees `frame_n` low and `lad_in` = 0000b. That edge is accepted in any state, so it also restarts a frame. A low strobe with any other nibble starts nothing.
- R2: The cycle-type nibble is accepted only when bits 3:2 are 01b. Bit 1 = 0 means read, and a read also needs bit 0 = 0. Bit 1 = 1 means write, and bit 0 is then ignored. Any other nibble makes the block ignore the frame: the bus is never driven and no strobe is issued.
- R3: The address is taken from eight nibbles, most significant first. Bits 31 to 23 must all be 1. Otherwise the frame is ignored, with no bus drive and no strobe.
- R4: Address bits 21:18 must equal the bitwise inverse of `id_strap[3:0]`. On a mismatch the frame is ignored, with no bus drive and no strobe.
- R5: For an accepted frame, `mem_sel_array` equals address bit 22 (1 for the array, 0 for registers), and `mem_addr` equals address bits `MEM_AW-1:0`.
- R6: In a read, the block leaves the bus undriven during the first cycle after the address. It drives 1111b during the second cycle.
- R7: A read then drives 0101b for two cycles, 0000b for one cycle, and then the data byte as two nibbles, bits 3:0 first and bits 7:4 second.
- R8: Every completed transfer ends with one cycle of 1111b driven by the block. The bus is released (`lad_oe` = 0) in the cycle after that.
- R9: In a write, the data byte arrives as two nibbles, low nibble first. The bus stays undriven through those two cycles and the first turnaround cycle. The block then drives 1111b, then 0000b, then the closing 1111b.
- R10: `mem_wr` pulses high for exactly one clock, right after the second write data nibble is captured. It carries the received byte on `mem_wdata`.
- R11: A low `frame_n` during a transfer makes `lad_oe` go low in the very next cycle. A write whose second data nibble was already captured still produces its `mem_wr` pulse. A write aborted earlier produces none.
- R12: In a read, `mem_rd` pulses for one clock during the first wait sync. The byte on `mem_rdata` is captured at the end of the second wait sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble bus as seen by the target |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Target drive enable for the nibble bus |
| id_strap | input | 4 | Device-number straps (inverted against address bits 21:18) |
| mem_addr | output | MEM_AW | Byte address to the internal port |
| mem_sel_array | output | 1 | 1 selects array, 0 selects register space |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rd | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read byte returned by the internal port |

## Verification
The assertions assume that `id_strap` only changes while no frame is in progress. They also assume that `mem_rdata` is valid, as a function of `mem_addr`, by the end of the second wait sync. The stimulus changes the straps only between transactions and models the internal port combinationally, so both assumptions always hold. Random frames mix legal reads and writes with bad cycle types, broken upper address bits and ID mismatches. Aborts are steered into specific states so that both the committed and the discarded write cases are reached.

// File: rtl/lpcfw_pkg.sv
package lpcfw_pkg;
    localparam int NIB_W     = 4;
    localparam int ADDR_NIBS = 8;
    localparam int CNT_W     = $clog2(ADDR_NIBS);

    localparam logic [NIB_W-1:0] NIB_START = 4'h0;
    localparam logic [NIB_W-1:0] NIB_WAIT  = 4'h5;
    localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
    localparam logic [NIB_W-1:0] NIB_TAR   = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CYC, ST_ADDR,
        ST_R_TAR0, ST_R_TAR1, ST_R_SW0, ST_R_SW1, ST_R_RDY, ST_R_D0, ST_R_D1,
        ST_W_D0, ST_W_D1, ST_W_TAR0, ST_W_TAR1, ST_W_SYNC,
        ST_END_TAR
    } lpc_state_t;
endpackage

// File: rtl/lpcfw_addr_chk.sv
module lpcfw_addr_chk (
    input  logic [31:0] addr,
    input  logic [3:0]  id_strap,
    output logic        hit,
    output logic        is_array
);
    logic upper_ok;
    logic id_ok;

    always_comb begin
        upper_ok = &addr[31:23];
        id_ok    = (addr[21:18] == ~id_strap);
        hit      = upper_ok && id_ok;
        is_array = addr[22];
    end
endmodule

// File: rtl/lpcfw_nib_drv.sv
module lpcfw_nib_drv
    import lpcfw_pkg::*;
(
    input  lpc_state_t       state,
    input  logic [7:0]       rdata,
    output logic [NIB_W-1:0] lad_out,
    output logic             lad_oe
);
    always_comb begin
        lad_out = NIB_TAR;
        lad_oe  = 1'b1;
        unique case (state)
            ST_R_TAR1, ST_W_TAR1, ST_END_TAR: lad_out = NIB_TAR;
            ST_R_SW0, ST_R_SW1:               lad_out = NIB_WAIT;
            ST_R_RDY, ST_W_SYNC:              lad_out = NIB_READY;
            ST_R_D0:                          lad_out = rdata[3:0];
            ST_R_D1:                          lad_out = rdata[7:4];
            default:                          lad_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpc_fw_target.sv
module lpc_fw_target
    import lpcfw_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        id_strap,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_sel_array,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata
);
    localparam int SH_W = NIB_W * (ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

    lpc_state_t        state, nxt;
    logic              dir_wr;
    logic [CNT_W-1:0]  cnt;
    logic [SH_W-1:0]   addr_sh;
    logic [31:0]       addr_full;
    logic [7:0]        rdata_q;
    logic              type_ok, hit, is_array;

    assign addr_full = {addr_sh, lad_in};
    assign type_ok   = (lad_in[3:2] == 2'b01) && (lad_in[1] || !lad_in[0]);

    lpcfw_addr_chk u_chk (
        .addr     (addr_full),
        .id_strap (id_strap),
        .hit      (hit),
        .is_array (is_array)
    );

    lpcfw_nib_drv u_drv (
        .state   (state),
        .rdata   (rdata_q),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    always_comb begin
        nxt = state;
        if (!frame_n) begin
            nxt = (lad_in == NIB_START) ? ST_CYC : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_CYC:     nxt = type_ok ? ST_ADDR : ST_IDLE;
                ST_ADDR:    if (cnt == CNT_LAST)
                                nxt = !hit ? ST_IDLE : (dir_wr ? ST_W_D0 : ST_R_TAR0);
                ST_R_TAR0:  nxt = ST_R_TAR1;
                ST_R_TAR1:  nxt = ST_R_SW0;
                ST_R_SW0:   nxt = ST_R_SW1;
                ST_R_SW1:   nxt = ST_R_RDY;
                ST_R_RDY:   nxt = ST_R_D0;
                ST_R_D0:    nxt = ST_R_D1;
                ST_R_D1:    nxt = ST_END_TAR;
                ST_W_D0:    nxt = ST_W_D1;
                ST_W_D1:    nxt = ST_W_TAR0;
                ST_W_TAR0:  nxt = ST_W_TAR1;
                ST_W_TAR1:  nxt = ST_W_SYNC;
                ST_W_SYNC:  nxt = ST_END_TAR;
                ST_END_TAR: nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_wr        <= 1'b0;
            cnt           <= '0;
            addr_sh       <= '0;
            mem_addr      <= '0;
            mem_sel_array <= 1'b0;
            mem_wdata     <= '0;
            rdata_q       <= '0;
        end else if (frame_n) begin
            unique case (state)
                ST_CYC: begin
                    dir_wr <= lad_in[1];
                    cnt    <= '0;
                end
                ST_ADDR: begin
                    addr_sh <= addr_full[SH_W-1:0];
                    cnt     <= cnt + 1'b1;
                    if (cnt == CNT_LAST) begin
                        mem_addr      <= addr_full[MEM_AW-1:0];
                        mem_sel_array <= is_array;
                    end
                end
                ST_W_D0:  mem_wdata[3:0] <= lad_in;
                ST_W_D1:  mem_wdata[7:4] <= lad_in;
                ST_R_SW1: rdata_q        <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign mem_wr = (state == ST_W_TAR0);
    assign mem_rd = (state == ST_R_SW0);

    AST_ABORT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);                                          // R11
    AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END_TAR) |=> !lad_oe);                             // R8
    AST_HOST_TAR_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_TAR0) |-> !lad_oe);                              // R6
    AST_SECOND_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_SW0 && frame_n) |=> (lad_oe && lad_out == NIB_WAIT)); // R7
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);                                            // R10
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);                                            // R12
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                           // R10
endmodule

// File: tb/tb_lpc_fw_target.sv
module tb_lpc_fw_target;
    localparam int MEM_AW = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_n = 1'b1;
    logic [3:0]        lad_in = 4'hF;
    logic [3:0]        lad_out;
    logic              lad_oe;
    logic [3:0]        id_strap = 4'h0;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_sel_array;
    logic              mem_wr;
    logic [7:0]        mem_wdata;
    logic              mem_rd;
    logic [7:0]        mem_rdata;

    int nvec = 0;
    int nbad = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [MEM_AW-1:0] w_addr;
    logic [7:0]        w_data;
    logic              w_sel;

    always #2 clk = ~clk;

    function automatic logic [7:0] model(input logic sel, input logic [MEM_AW-1:0] a);
        return sel ? (a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]}) : (a[7:0] + 8'h3C);
    endfunction

    assign mem_rdata = model(mem_sel_array, mem_addr);

    always @(posedge clk) begin
        if (rst_n && mem_wr) begin
            wcnt   <= wcnt + 1;
            w_addr <= mem_addr;
            w_data <= mem_wdata;
            w_sel  <= mem_sel_array;
        end
        if (rst_n && mem_rd) rcnt <= rcnt + 1;
    end

    lpc_fw_target #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(id_strap),
        .mem_addr(mem_addr), .mem_sel_array(mem_sel_array), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] obs();
        return lad_oe ? {4'h1, lad_out} : 8'h00;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic tick(input logic f, input logic [3:0] n);
        frame_n = f;
        lad_in  = n;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_addr(input logic sel, input logic [3:0] ids,
                                            input logic [MEM_AW-1:0] low);
        logic [31:0] a;
        a = {9'h1FF, sel, ~ids, 18'd0};
        a[MEM_AW-1:0] = low;
        return a;
    endfunction

    task automatic send_hdr(input logic [3:0] ct, input logic [31:0] a);
        tick(1'b0, 4'h0);
        tick(1'b1, ct);
        for (int i = 7; i >= 0; i--) tick(1'b1, a[i*4 +: 4]);
    endtask

    task automatic ignored_tail(input string rq, input int w0);
        for (int i = 0; i < 8; i++) begin
            chk(rq, obs(), 8'h00);
            tick(1'b1, 4'hF);
        end
        chk(rq, wcnt, w0);
    endtask

    task automatic do_read(input logic [31:0] a, input logic hit);
        int r0, w0;
        logic [7:0] d;
        r0 = rcnt; w0 = wcnt;
        d  = model(a[22], a[MEM_AW-1:0]);
        send_hdr(4'b0100, a);
        if (!hit) begin
            ignored_tail("R4/R3 read ignored", w0);
            chk("R4/R3 no rd", rcnt, r0);
            return;
        end
        chk("R6 host tar", obs(), 8'h00);  tick(1'b1, 4'hF);
        chk("R6 target tar", obs(), 8'h1F); tick(1'b1, 4'hF);
        chk("R7 wait1", obs(), 8'h15);     tick(1'b1, 4'hF);
        chk("R7 wait2", obs(), 8'h15);
        chk("R12 rd strobe", rcnt, r0 + 1); tick(1'b1, 4'hF);
        chk("R7 ready", obs(), 8'h10);     tick(1'b1, 4'hF);
        chk("R7 R5 data lo", obs(), {4'h1, d[3:0]}); tick(1'b1, 4'hF);
        chk("R7 R5 data hi", obs(), {4'h1, d[7:4]}); tick(1'b1, 4'hF);
        chk("R8 end tar", obs(), 8'h1F);   tick(1'b1, 4'hF);
        chk("R8 release", obs(), 8'h00);
        chk("R12 single rd", rcnt, r0 + 1);
        chk("R5 addr", mem_addr, a[MEM_AW-1:0]);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [7:0] d, input logic hit);
        int w0;
        w0 = wcnt;
        send_hdr({3'b011, 1'($urandom % 2)}, a);
        if (!hit) begin
            tick(1'b1, d[3:0]);
            tick(1'b1, d[7:4]);
            ignored_tail("R4/R3 write ignored", w0);
            return;
        end
        chk("R9 data lo", obs(), 8'h00);  tick(1'b1, d[3:0]);
        chk("R9 data hi", obs(), 8'h00);  tick(1'b1, d[7:4]);
        chk("R9 host tar", obs(), 8'h00); tick(1'b1, 4'hF);
        chk("R9 target tar", obs(), 8'h1F); tick(1'b1, 4'hF);
        chk("R9 sync", obs(), 8'h10);     tick(1'b1, 4'hF);
        chk("R8 end tar", obs(), 8'h1F);  tick(1'b1, 4'hF);
        chk("R8 release", obs(), 8'h00);
        chk("R10 one strobe", wcnt, w0 + 1);
        chk("R10 data", w_data, d);
        chk("R5 addr", w_addr, a[MEM_AW-1:0]);
        chk("R5 sel", w_sel, a[22]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        nvec++; nbad++;
        $display("FAIL R1 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] a;
        int w0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R8 reset float", obs(), 8'h00);
        chk("R10 reset wr", mem_wr, 1'b0);
        chk("R12 reset rd", mem_rd, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 inverted strap polarity
        id_strap = 4'h0;
        do_read(mk_addr(1'b1, 4'h0, 18'h12345), 1'b1);
        a = mk_addr(1'b1, 4'h0, 18'h00ABC); a[21:18] = 4'h0;
        do_read(a, 1'b0);
        id_strap = 4'hA;
        do_write(mk_addr(1'b0, 4'hA, 18'h3FFFF), 8'hC3, 1'b1);

        // R1 non-start nibble with strobe low
        w0 = wcnt;
        tick(1'b0, 4'h3);
        tick(1'b1, 4'b0110);
        for (int i = 0; i < 8; i++) tick(1'b1, 4'hF);
        ignored_tail("R1 bad start", w0);

        // R2 read with bit 0 set
        w0 = wcnt;
        send_hdr(4'b0101, mk_addr(1'b1, id_strap, 18'h1));
        ignored_tail("R2 read bit0", w0);

        // R11 abort mid-read, then restart immediately (R1)
        send_hdr(4'b0100, mk_addr(1'b1, id_strap, 18'h00777));
        tick(1'b1, 4'hF); tick(1'b1, 4'hF);
        chk("R11 driving before abort", obs(), 8'h15);
        tick(1'b0, 4'hF);
        chk("R11 abort float", obs(), 8'h00);
        do_read(mk_addr(1'b0, id_strap, 18'h00777), 1'b1);

        // R11 abort after full write data: committed
        w0 = wcnt;
        send_hdr(4'b0110, mk_addr(1'b1, id_strap, 18'h0BEEF));
        tick(1'b1, 4'h9); tick(1'b1, 4'h6);
        tick(1'b0, 4'hF);
        chk("R11 abort float wr", obs(), 8'h00);
        chk("R11 committed", wcnt, w0 + 1);
        chk("R11 committed data", w_data, 8'h69);

        // R11 abort during write data: discarded
        w0 = wcnt;
        send_hdr(4'b0111, mk_addr(1'b1, id_strap, 18'h00001));
        tick(1'b1, 4'h2);
        tick(1'b0, 4'hF);
        ignored_tail("R11 discarded", w0);

        // random mix
        for (int t = 0; t < 150; t++) begin
            int kind;
            logic [7:0] d;
            id_strap = 4'($urandom);
            kind = $urandom % 8;
            a = mk_addr(1'($urandom), id_strap, MEM_AW'($urandom));
            d = 8'($urandom);
            if (kind == 0) begin
                w0 = wcnt;
                send_hdr({~2'($urandom % 3 + 1) ^ 2'b10 ^ 2'b11 == 2'b01 ? 2'b00 : 2'($urandom % 3 + 1) ^ 2'b01, 2'($urandom)}, a);
                ignored_tail("R2 bad type", w0);
            end else if (kind == 1) begin
                a[21:18] = id_strap ^ 4'(($urandom % 15) + 1) ^ 4'hF;
                if ($urandom % 2) do_read(a, 1'b0); else do_write(a, d, 1'b0);
            end else if (kind == 2) begin
                a[23 + ($urandom % 9)] = 1'b0;
                if ($urandom % 2) do_read(a, 1'b0); else do_write(a, d, 1'b0);
            end else begin
                if ($urandom % 2) do_read(a, 1'b1); else do_write(a, d, 1'b1);
            end
        end
        finish_run();
    end
endmodule